// File: doc/BRIEF.md
# Bidirectional Prescaled Event Counter

This block is a 16-bit counter whose steps are paced by an 8-bit clock divider. It runs in one of two directions schemes: a sawtooth that climbs to a limit and falls back to zero at once, or a triangle that climbs to the limit and then descends step by step to zero before climbing again. A one-cycle pulse marks every step taken at the limit, and a status flag reports when the triangle is on its falling side.

Software controls the counter through a single control word. Two freeze levels exist. The deep freeze stops counting and also blocks every event input. The light freeze stops counting but keeps watching a vector of event inputs. An event that is enabled in the start mask releases the light freeze and counting resumes. A self-clearing bit in the same word zeroes the count and the divider.

Top module: `bidir_prescale_counter`

## Requirements
- R1: After reset the count is 0, the falling flag is 0, the limit pulse is 0, and the read-back word shows the deep freeze set, the light freeze clear, sawtooth mode and a divider setting of 0.
- R2: While running, the count takes one step every (DIV+1) clocks, where DIV is the 8-bit divider field of the control word.
- R3: In sawtooth mode (mode bit 0 = 0) the count rises by one per step and, on a step taken at count == limit, goes to 0 while the limit pulse is high for that one cycle.
- R4: In triangle mode (mode bit = 1) a step taken at count == limit on the rising side makes the count fall by one, raises the falling flag and pulses the limit output; the falling side steps down by one and clears the flag on the step that reaches 0, after which counting rises again.
- R5: While the deep freeze bit (bit 2) is 1 the count does not move and event inputs have no effect; writing the deep freeze bit as 1 forces the light freeze bit to read 0.
- R6: While the light freeze bit (bit 1) is 1 and the deep freeze bit is 0 the count does not move.
- R7: During a light freeze, an event input that is also set in the start mask clears the light freeze bit on the next clock; events outside the mask leave it set.
- R8: One write with bit 2 = 0 and bit 1 = 1 leaves the block in the light freeze and not in the deep freeze.
- R9: A write with the clear bit (bit 3) set zeroes the count and the falling flag on that clock and restarts the divider, so the next step comes a full (DIV+1) clocks later; the clear bit reads back as 0.
- R10: The control word is laid out as bit 0 mode, bit 1 light freeze, bit 2 deep freeze, bit 3 clear, bits 11:4 divider; the read-back word has the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word to write |
| ctl_rdata | output | 12 | Control word read-back |
| limit_val | input | 16 | Limit compared against the count |
| evt_in | input | 4 | Event inputs |
| evt_mask | input | 4 | Start mask for the event inputs |
| count | output | 16 | Current count |
| count_down | output | 1 | High while on the falling side in triangle mode |
| limit_hit | output | 1 | One-cycle pulse on each step taken at the limit |

## Verification
A divider that keeps its phase across a clear shows up as a first step earlier than DIV+1 clocks after the clear write, so the gap to that first step is measured exactly. A falling flag stuck in the wrong state shows within one step as a count moving the wrong way, and the scoreboard compares every step value, flag and pulse with the gap since the previous step. A freeze bit in the wrong state shows up as a count that moves when it should be frozen, or the reverse, within DIV+1 clocks, and the read-back word shows it on the clock after the write or event.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  // control word field positions (shared by write and read-back)
  localparam int CTL_MODE_BIT = 0;
  localparam int CTL_LITE_BIT = 1;
  localparam int CTL_DEEP_BIT = 2;
  localparam int CTL_CLR_BIT  = 3;
  localparam int CTL_DIV_LSB  = 4;

  typedef enum logic {
    MODE_SAW = 1'b0,
    MODE_TRI = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/bpc_ctrl_regs.sv
module bpc_ctrl_regs #(
  parameter int DIV_W = 8,
  parameter int N_EVT = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      wr_mode,
  input  logic                      wr_lite,
  input  logic                      wr_deep,
  input  logic                      wr_clr,
  input  logic [DIV_W-1:0]          wr_div,
  input  logic [N_EVT-1:0]          evt_in,
  input  logic [N_EVT-1:0]          evt_mask,
  output bpc_pkg::cnt_mode_e        mode_q,
  output logic                      lite_q,
  output logic                      deep_q,
  output logic [DIV_W-1:0]          div_q,
  output logic                      clr_now,
  output logic                      run
);
  logic evt_go;

  assign evt_go  = |(evt_in & evt_mask);
  assign clr_now = wr_en & wr_clr;
  assign run     = ~deep_q & ~lite_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= bpc_pkg::MODE_SAW;
      lite_q <= 1'b0;
      deep_q <= 1'b1;
      div_q  <= '0;
    end else if (wr_en) begin
      mode_q <= bpc_pkg::cnt_mode_e'(wr_mode);
      div_q  <= wr_div;
      deep_q <= wr_deep;
      // deep freeze overrides the light one
      lite_q <= wr_lite & ~wr_deep;
    end else if (~deep_q && lite_q && evt_go) begin
      lite_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bpc_prescaler.sv
module bpc_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic             at_end;

  // >= keeps the divider sane if the setting drops below the phase
  assign at_end = (phase_q >= div_val);
  assign tick   = run & at_end & ~restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (at_end) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpc_count_core.sv
module bpc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               zero_now,
  input  bpc_pkg::cnt_mode_e mode,
  input  logic [CNT_W-1:0]   limit,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               fall_q,
  output logic               hit_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_limit;
  assign at_limit = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fall_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      if (zero_now) begin
        cnt_q  <= '0;
        fall_q <= 1'b0;
      end else if (tick) begin
        if (mode == bpc_pkg::MODE_SAW) begin
          fall_q <= 1'b0;
          if (at_limit) begin
            cnt_q <= '0;
            hit_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end else if (!fall_q) begin
          if (at_limit) begin
            hit_q <= 1'b1;
            if (limit == '0) begin
              cnt_q <= '0;
            end else begin
              cnt_q  <= cnt_q - ONE;
              fall_q <= (limit != ONE);
            end
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end else begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) fall_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bidir_prescale_counter.sv
module bidir_prescale_counter #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8,
  parameter int N_EVT = 4,
  localparam int CTL_W = DIV_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic [CNT_W-1:0] limit_val,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_EVT-1:0] evt_mask,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             limit_hit
);
  import bpc_pkg::*;

  cnt_mode_e        mode_q;
  logic             lite_q, deep_q, clr_now, run, tick;
  logic [DIV_W-1:0] div_q;

  bpc_ctrl_regs #(.DIV_W(DIV_W), .N_EVT(N_EVT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ctl_wr),
    .wr_mode  (ctl_wdata[CTL_MODE_BIT]),
    .wr_lite  (ctl_wdata[CTL_LITE_BIT]),
    .wr_deep  (ctl_wdata[CTL_DEEP_BIT]),
    .wr_clr   (ctl_wdata[CTL_CLR_BIT]),
    .wr_div   (ctl_wdata[CTL_DIV_LSB +: DIV_W]),
    .evt_in   (evt_in),
    .evt_mask (evt_mask),
    .mode_q   (mode_q),
    .lite_q   (lite_q),
    .deep_q   (deep_q),
    .div_q    (div_q),
    .clr_now  (clr_now),
    .run      (run)
  );

  bpc_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (clr_now),
    .div_val (div_q),
    .tick    (tick)
  );

  bpc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .zero_now (clr_now),
    .mode     (mode_q),
    .limit    (limit_val),
    .cnt_q    (count),
    .fall_q   (count_down),
    .hit_q    (limit_hit)
  );

  always_comb begin
    ctl_rdata                        = '0;
    ctl_rdata[CTL_MODE_BIT]          = (mode_q == MODE_TRI);
    ctl_rdata[CTL_LITE_BIT]          = lite_q;
    ctl_rdata[CTL_DEEP_BIT]          = deep_q;
    ctl_rdata[CTL_DIV_LSB +: DIV_W]  = div_q;
  end
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_any,
  input logic             wr_clr,
  input logic             wr_release,
  input logic             evt_go,
  input logic             st_lite,
  input logic             st_deep,
  input logic [CNT_W-1:0] count,
  input logic             count_down,
  input logic             limit_hit
);
  AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_deep && !wr_clr) |=> $stable(count)); // R5

  AST_DEEP_MASKS_LITE: assert property (@(posedge clk) disable iff (rst)
    st_deep |-> !st_lite); // R5

  AST_LITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_lite && !wr_clr) |=> $stable(count)); // R6

  AST_EVT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st_lite && !st_deep && !wr_any && evt_go) |=> !st_lite); // R7

  AST_RELEASE_TO_LITE: assert property (@(posedge clk) disable iff (rst)
    wr_release |=> (st_lite && !st_deep)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (count == '0 && !count_down)); // R9

  AST_FALL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(count_down) |-> limit_hit); // R4

  AST_ZERO_RISING: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> !count_down); // R4

  AST_HIT_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    limit_hit |-> $past(!st_deep && !st_lite)); // R3
endmodule

bind bidir_prescale_counter bpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_any     (ctl_wr),
  .wr_clr     (ctl_wr & ctl_wdata[bpc_pkg::CTL_CLR_BIT]),
  .wr_release (ctl_wr & ~ctl_wdata[bpc_pkg::CTL_DEEP_BIT] & ctl_wdata[bpc_pkg::CTL_LITE_BIT]),
  .evt_go     (|(evt_in & evt_mask)),
  .st_lite    (ctl_rdata[bpc_pkg::CTL_LITE_BIT]),
  .st_deep    (ctl_rdata[bpc_pkg::CTL_DEEP_BIT]),
  .count      (count),
  .count_down (count_down),
  .limit_hit  (limit_hit)
);

// File: tb/bidir_prescale_counter_test.sv
module bidir_prescale_counter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [11:0] ctl_wdata = '0;
  logic [11:0] ctl_rdata;
  logic [15:0] limit_val = 16'd3;
  logic [3:0]  evt_in = '0;
  logic [3:0]  evt_mask = '0;
  logic [15:0] count;
  logic        count_down;
  logic        limit_hit;

  int n_total = 0;
  int n_bad   = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [15:0] cnt;
    logic        dn;
    logic        hit;
    int          gap;
  } exp_t;
  exp_t sbq[$];
  bit          mon_en = 1'b0;
  logic [15:0] prev_cnt = '0;
  int          gap_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_prescale_counter uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .limit_val(limit_val), .evt_in(evt_in),
    .evt_mask(evt_mask), .count(count), .count_down(count_down),
    .limit_hit(limit_hit)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic [15:0] c, logic d, logic h, int g);
    exp_t e;
    e.cnt = c; e.dn = d; e.hit = h; e.gap = g;
    sbq.push_back(e);
  endtask

  // word layout: {div[7:0], clr, deep, lite, mode}
  task automatic wr_ctl(logic mode, logic lite, logic deep, logic clr, logic [7:0] dv);
    @(negedge clk);
    ctl_wr    = 1'b1;
    ctl_wdata = {dv, clr, deep, lite, mode};
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(posedge clk);
    mon_en = 1'b0;
  endtask

  task automatic mon_start();
    prev_cnt = count;
    gap_cnt  = 0;
    mon_en   = 1'b1;
  endtask

  // monitor: compares each count step with the next expected item
  always @(negedge clk) begin
    if (mon_en) begin
      gap_cnt++;
      if (count !== prev_cnt) begin
        if (sbq.size() == 0) begin
          check("R3/R4 unexpected step", {16'h0, count}, {16'h0, prev_cnt});
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check("R3/R4 step value", {16'h0, count}, {16'h0, e.cnt});
          check("R4 falling flag", {31'h0, count_down}, {31'h0, e.dn});
          check("R3/R4 limit pulse", {31'h0, limit_hit}, {31'h0, e.hit});
          if (e.gap != 0) check("R2 step gap", gap_cnt, e.gap);
        end
        gap_cnt = 0;
      end
    end
    prev_cnt = count;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10 reset state
    check("R1 count", {16'h0, count}, 0);
    check("R1 falling", {31'h0, count_down}, 0);
    check("R1 pulse", {31'h0, limit_hit}, 0);
    check("R1 R10 readback", {20'h0, ctl_rdata}, 32'h004);

    // R5 events ignored in deep freeze
    evt_in = 4'hF; evt_mask = 4'hF;
    repeat (5) @(negedge clk);
    check("R5 count held", {16'h0, count}, 0);
    check("R5 lite stays 0", {31'h0, ctl_rdata[1]}, 0);
    evt_in = 4'h0;

    // R3 sawtooth, R2 divider 2 -> gap 3
    limit_val = 16'd3;
    mon_start();
    push(1, 0, 0, 0); push(2, 0, 0, 3); push(3, 0, 0, 3);
    push(0, 0, 1, 3); push(1, 0, 0, 3); push(2, 0, 0, 3);
    wr_ctl(0, 0, 0, 0, 8'd2);
    check("R10 readback run", {20'h0, ctl_rdata}, 32'h020);
    drain();

    // R6 light freeze
    wr_ctl(0, 1, 0, 0, 8'd2);
    held = count;
    repeat (6) @(negedge clk);
    check("R6 count held", {16'h0, count}, {16'h0, held});
    check("R6 lite set", {31'h0, ctl_rdata[1]}, 1);

    // R7 unmasked event ignored
    evt_in = 4'b0001; evt_mask = 4'b0010;
    repeat (3) @(negedge clk);
    check("R7 unmasked keeps freeze", {31'h0, ctl_rdata[1]}, 1);
    check("R7 unmasked count held", {16'h0, count}, {16'h0, held});
    // R7 masked event restarts
    evt_in = 4'b0010;
    @(negedge clk);
    evt_in = 4'b0000;
    check("R7 masked releases", {31'h0, ctl_rdata[1]}, 0);
    repeat (3) @(negedge clk);
    check("R7 counting resumed", {31'h0, (count != held)}, 1);

    // R5 deep write forces lite to 0
    wr_ctl(0, 1, 1, 0, 8'd2);
    check("R5 deep forces lite 0", {30'h0, ctl_rdata[2:1]}, 2);
    held = count;
    evt_in = 4'hF;
    repeat (4) @(negedge clk);
    evt_in = 4'h0;
    check("R5 deep count held", {16'h0, count}, {16'h0, held});

    // R9 clear while deep frozen
    wr_ctl(0, 0, 1, 1, 8'd2);
    check("R9 clear zeroes", {16'h0, count}, 0);
    check("R9 clear reads 0", {31'h0, ctl_rdata[3]}, 0);

    // R8 release deep into light freeze
    wr_ctl(0, 1, 0, 0, 8'd2);
    check("R8 light not deep", {30'h0, ctl_rdata[2:1]}, 1);
    repeat (5) @(negedge clk);
    check("R8 count held", {16'h0, count}, 0);
    evt_in = 4'b0010;
    @(negedge clk);
    evt_in = 4'b0000;
    repeat (3) @(negedge clk);
    check("R8 R7 restart step after 3", {16'h0, count}, 1);

    // R9 clear restarts the divider: divider 7 -> first step 8 clocks later
    limit_val = 16'd1000;
    wr_ctl(0, 0, 0, 0, 8'd7);
    repeat (23) @(negedge clk);
    wr_ctl(0, 0, 0, 1, 8'd7);
    check("R9 zero after clear", {16'h0, count}, 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      check("R9 no early step", {16'h0, count}, 0);
    end
    @(negedge clk);
    check("R9 R2 step after full period", {16'h0, count}, 1);

    // R4 triangle, divider 0
    wr_ctl(1, 0, 1, 1, 8'd0);
    limit_val = 16'd3;
    mon_start();
    push(1, 0, 0, 0); push(2, 0, 0, 1); push(3, 0, 0, 1);
    push(2, 1, 1, 1); push(1, 1, 0, 1); push(0, 0, 0, 1);
    push(1, 0, 0, 1); push(2, 0, 0, 1); push(3, 0, 0, 1);
    push(2, 1, 1, 1);
    wr_ctl(1, 0, 0, 0, 8'd0);
    drain();

    // R3 sawtooth, R2 divider 4 -> gap 5
    wr_ctl(0, 0, 1, 1, 8'd4);
    limit_val = 16'd2;
    mon_start();
    push(1, 0, 0, 0); push(2, 0, 0, 5); push(0, 0, 1, 5);
    push(1, 0, 0, 5); push(2, 0, 0, 5); push(0, 0, 1, 5);
    wr_ctl(0, 0, 0, 0, 8'd4);
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule